// File: doc/BRIEF.md
# Fault-Aware Three-Level Gate-State Selector

This block chooses the switch pattern for the motor phase that is being driven in a four-phase, three-level asymmetric half-bridge drive with fault-recovery switches. Each update combines several inputs into one registered gate word:

- the three-level switching request from the current hysteresis comparator,
- the sign of the difference between the upper and lower DC-link capacitor voltages,
- the fault record from an external diagnosis stage: device index, phase and open/short kind.

The gate word covers the eight switches of the driven phase, four switches borrowed from a helper phase and the shared bidirectional neutral-point switch.

A healthy phase uses the normal pattern set. In that set the half-voltage request is steered by the capacitor imbalance so that the two capacitors stay balanced. When the diagnosed fault sits on the driven phase, the selector moves to recovery patterns instead. These patterns use spare switches of the faulted leg, borrow switches from the phase two positions ahead (wrapping over four phases) and open the neutral-point switch when the full voltage must be reached. Capacitor balancing pauses while the faulted phase is driven and comes back on its own as soon as a healthy phase is selected. Outputs change only on an update strobe.

Top module: `gate_state_selector`

## Requirements
- R1: During synchronous reset (`rst` high at a clock edge) every gate output goes to 0, `np_closed` goes to 1 and `help_phase` goes to 0.
- R2: Outputs take new values only at a clock edge where `upd` is 1, and they take them at that edge. At edges where `upd` is 0, all outputs hold.
- R3: A healthy phase with `gamma`=2'b01 (+1) gives `gate_main`=8'h0F, where bit k-1 is switch Sk (S1 to S4 on, S5 to S8 off), `gate_help`=0 and `np_closed`=1.
- R4: `gamma`=2'b11 (−1), and the reserved code 2'b10, give all gates off with `np_closed`=1. This holds whether the phase is healthy or faulted.
- R5: A healthy phase with `gamma`=2'b00 (0) balances the capacitors. A negative signed `cap_diff` (upper minus lower) turns S1, S2 and S3 on with S4 off (`gate_main`=8'h07). A zero or positive `cap_diff` turns S2, S3 and S4 on with S1 off (8'h0E). In both cases `np_closed`=1 and `gate_help`=0.
- R6: `help_phase` is (`phase`+2) mod 4, so phase 3 borrows from phase 1 and phase 2 borrows from phase 0 (phases numbered 0 to 3).
- R7: An open fault on device 1 of the driven phase with `gamma`=+1 gives S2, S3 and S4 on (8'h0E). It also turns on helper switches S1s and S5s (`gate_help` bits 0 and 2, value 4'h5) and sets `np_closed`=0.
- R8: With `gamma`=+1, an open fault on device 2, or a short fault on device 1 or 2, gives S3, S4 and S8 on (8'h8C), `gate_help`=4'h5 and `np_closed`=0.
- R9: A fault of either kind on device 1 or 2 with `gamma`=0 gives S3, S4 and S8 on (8'h8C), `gate_help`=0 and `np_closed`=1, whatever the sign of `cap_diff`.
- R10: A fault of either kind on device 3 or 4 with `gamma`=+1 gives S1, S2 and S7 on (8'h43) with helper switches S4s and S6s (`gate_help` bits 1 and 3, value 4'hA) and `np_closed`=0. With `gamma`=0 it gives 8'h43, `gate_help`=0 and `np_closed`=1.
- R11: A fault record is used only when `flt_phase` equals `phase` and `flt_dev` is in the range 1 to 4. A `flt_dev` of 0 means no fault, and values 5 to 7 are also treated as no fault. In every other case the normal patterns of R3 and R5 apply, so balancing resumes on a healthy phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | State-update strobe |
| phase | input | 2 | Index of the driven phase |
| gamma | input | 2 | Switching request: 01 = +1, 00 = 0, 11 = −1, 10 = reserved (treated as −1) |
| cap_diff | input | 12 | Signed upper-minus-lower capacitor voltage difference |
| flt_dev | input | 3 | Faulted device index, 1 to 4; 0 means none |
| flt_phase | input | 2 | Phase that holds the fault |
| flt_short | input | 1 | Fault kind: 1 = short circuit, 0 = open circuit |
| gate_main | output | 8 | Gates S1 to S8 of the driven phase, bit k-1 = Sk |
| gate_help | output | 4 | Helper gates: bit0 S1s, bit1 S4s, bit2 S5s, bit3 S6s |
| help_phase | output | 2 | Index of the helper phase |
| np_closed | output | 1 | Neutral-point switch closed when 1 |

## Verification
The bench aims at the points where the recovery patterns part from the normal ones:

- An open fault and a short fault on device 1 must give different full-voltage states. A design that merges them would drive S2 where S8 belongs.
- A zero `cap_diff` must pick the S1-off half pattern. A design that compares the wrong way, or uses a strict inequality, would invert the balancing.
- A fault on a different phase, or a device index above 4, must leave the normal table in use. A design that matches on device alone would open the neutral point on healthy phases.
- Helper wrap-around from phase 3 to phase 1, and the reserved `gamma` code, catch a helper index that does not wrap and a demagnetizing state that does not decode all four codes.

// File: rtl/gsel_pkg.sv
package gsel_pkg;

    typedef enum logic [1:0] {
        GAM_ZERO = 2'b00,
        GAM_POS  = 2'b01,
        GAM_RSV  = 2'b10,
        GAM_NEG  = 2'b11
    } gamma_e;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_FULL,
        ST_HALF_S123,
        ST_HALF_S234,
        ST_REC_NO_S1,
        ST_REC_S8_FULL,
        ST_REC_S8_HALF,
        ST_REC_S7_FULL,
        ST_REC_S7_HALF
    } gstate_e;

    typedef struct packed {
        logic [7:0] main;
        logic [3:0] help;
        logic       np_closed;
    } gate_word_t;

    localparam gate_word_t GW_SAFE = '{main: 8'h00, help: 4'h0, np_closed: 1'b1};

    function automatic logic dev_valid(input logic [2:0] dev);
        return (dev >= 3'd1) && (dev <= 3'd4);
    endfunction

    function automatic int unsigned wrap_idx(input int unsigned base,
                                             input int unsigned ofs,
                                             input int unsigned n);
        return (base + ofs) % n;
    endfunction

endpackage

// File: rtl/gsel_decode.sv
module gsel_decode
    import gsel_pkg::*;
#(
    parameter int DIFF_W = 12,
    parameter int PH_W   = 2
) (
    input  logic [PH_W-1:0]          phase,
    input  logic [1:0]               gamma,
    input  logic signed [DIFF_W-1:0] cap_diff,
    input  logic [2:0]               flt_dev,
    input  logic [PH_W-1:0]          flt_phase,
    input  logic                     flt_short,
    output gstate_e                  state
);
    logic    hit;
    logic    low_pair;
    gamma_e  g;

    assign g        = gamma_e'(gamma);
    assign hit      = dev_valid(flt_dev) && (flt_phase == phase);
    assign low_pair = (flt_dev == 3'd1) || (flt_dev == 3'd2);

    always_comb begin
        state = ST_OFF;
        unique case (g)
            GAM_NEG, GAM_RSV: state = ST_OFF;
            GAM_POS: begin
                if (!hit)
                    state = ST_FULL;
                else if (low_pair)
                    state = (flt_dev == 3'd1 && !flt_short) ? ST_REC_NO_S1 : ST_REC_S8_FULL;
                else
                    state = ST_REC_S7_FULL;
            end
            GAM_ZERO: begin
                if (!hit)
                    state = (cap_diff < 0) ? ST_HALF_S123 : ST_HALF_S234;
                else if (low_pair)
                    state = ST_REC_S8_HALF;
                else
                    state = ST_REC_S7_HALF;
            end
            default: state = ST_OFF;
        endcase
    end
endmodule

// File: rtl/gsel_pattern.sv
module gsel_pattern
    import gsel_pkg::*;
(
    input  gstate_e    state,
    output gate_word_t word
);
    always_comb begin
        word = GW_SAFE;
        unique case (state)
            ST_OFF:         word = GW_SAFE;
            ST_FULL:        word = '{main: 8'h0F, help: 4'h0, np_closed: 1'b1};
            ST_HALF_S123:   word = '{main: 8'h07, help: 4'h0, np_closed: 1'b1};
            ST_HALF_S234:   word = '{main: 8'h0E, help: 4'h0, np_closed: 1'b1};
            ST_REC_NO_S1:   word = '{main: 8'h0E, help: 4'h5, np_closed: 1'b0};
            ST_REC_S8_FULL: word = '{main: 8'h8C, help: 4'h5, np_closed: 1'b0};
            ST_REC_S8_HALF: word = '{main: 8'h8C, help: 4'h0, np_closed: 1'b1};
            ST_REC_S7_FULL: word = '{main: 8'h43, help: 4'hA, np_closed: 1'b0};
            ST_REC_S7_HALF: word = '{main: 8'h43, help: 4'h0, np_closed: 1'b1};
            default:        word = GW_SAFE;
        endcase
    end
endmodule

// File: rtl/gsel_outreg.sv
module gsel_outreg
    import gsel_pkg::*;
#(
    parameter int PH_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            upd,
    input  gate_word_t      word_d,
    input  logic [PH_W-1:0] help_d,
    output gate_word_t      word_q,
    output logic [PH_W-1:0] help_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= GW_SAFE;
            help_q <= '0;
        end else if (upd) begin
            word_q <= word_d;
            help_q <= help_d;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(word_q) && $stable(help_q)));

    p_helper_np_r7: assert property (@(posedge clk) disable iff (rst)
        (word_q.help != 4'h0) |-> !word_q.np_closed);

    p_np_open_helper_r8: assert property (@(posedge clk) disable iff (rst)
        !word_q.np_closed |-> (word_q.help != 4'h0));

    p_helper_pair_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(word_q.help) == 0 || $countones(word_q.help) == 2);
endmodule

// File: rtl/gate_state_selector.sv
module gate_state_selector
    import gsel_pkg::*;
#(
    parameter int NUM_PHASES = 4,
    parameter int HELP_OFS   = 2,
    parameter int DIFF_W     = 12,
    localparam int PH_W      = $clog2(NUM_PHASES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     upd,
    input  logic [PH_W-1:0]          phase,
    input  logic [1:0]               gamma,
    input  logic signed [DIFF_W-1:0] cap_diff,
    input  logic [2:0]               flt_dev,
    input  logic [PH_W-1:0]          flt_phase,
    input  logic                     flt_short,
    output logic [7:0]               gate_main,
    output logic [3:0]               gate_help,
    output logic [PH_W-1:0]          help_phase,
    output logic                     np_closed
);
    gstate_e         st;
    gate_word_t      word_d;
    gate_word_t      word_q;
    logic [PH_W-1:0] help_d;
    logic [PH_W-1:0] help_q;

    gsel_decode #(.DIFF_W(DIFF_W), .PH_W(PH_W)) u_dec (
        .phase(phase), .gamma(gamma), .cap_diff(cap_diff),
        .flt_dev(flt_dev), .flt_phase(flt_phase), .flt_short(flt_short),
        .state(st)
    );

    gsel_pattern u_pat (.state(st), .word(word_d));

    assign help_d = PH_W'(wrap_idx(int'(phase), HELP_OFS, NUM_PHASES));

    gsel_outreg #(.PH_W(PH_W)) u_reg (
        .clk(clk), .rst(rst), .upd(upd),
        .word_d(word_d), .help_d(help_d),
        .word_q(word_q), .help_q(help_q)
    );

    assign gate_main  = word_q.main;
    assign gate_help  = word_q.help;
    assign np_closed  = word_q.np_closed;
    assign help_phase = help_q;

    p_demag_r4: assert property (@(posedge clk) disable iff (rst)
        (upd && gamma[1]) |=> (gate_main == 8'h00 && gate_help == 4'h0 && np_closed));

    p_full_np_r3: assert property (@(posedge clk) disable iff (rst)
        (gate_main[3:0] == 4'hF) |-> np_closed);

    p_healthy_np_r11: assert property (@(posedge clk) disable iff (rst)
        (upd && !dev_valid(flt_dev)) |=> np_closed);

    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        upd |=> (int'(help_phase) == (int'($past(phase)) + HELP_OFS) % NUM_PHASES));
endmodule

// File: tb/tb_gate_state_selector.sv
module tb_gate_state_selector;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              upd;
    logic [1:0]        phase;
    logic [1:0]        gamma;
    logic signed [11:0] cap_diff;
    logic [2:0]        flt_dev;
    logic [1:0]        flt_phase;
    logic              flt_short;
    logic [7:0]        gate_main;
    logic [3:0]        gate_help;
    logic [1:0]        help_phase;
    logic              np_closed;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_state_selector dut (
        .clk(clk), .rst(rst), .upd(upd), .phase(phase), .gamma(gamma),
        .cap_diff(cap_diff), .flt_dev(flt_dev), .flt_phase(flt_phase),
        .flt_short(flt_short), .gate_main(gate_main), .gate_help(gate_help),
        .help_phase(help_phase), .np_closed(np_closed)
    );

    task automatic expect_out(input string req, input logic [7:0] em,
                              input logic [3:0] eh, input logic enp,
                              input logic [1:0] ehp);
        n_chk++;
        if (gate_main !== em || gate_help !== eh || np_closed !== enp || help_phase !== ehp) begin
            n_bad++;
            $display("FAIL %s: got main=%h help=%h np=%b hp=%0d exp main=%h help=%h np=%b hp=%0d",
                     req, gate_main, gate_help, np_closed, help_phase, em, eh, enp, ehp);
        end
    endtask

    // Drive at negedge, strobe over one posedge, sample at following negedge.
    task automatic apply(input logic [1:0] ph, input logic [1:0] gm,
                         input int df, input logic [2:0] dv,
                         input logic [1:0] fp, input logic sh);
        @(negedge clk);
        phase = ph; gamma = gm; cap_diff = 12'(df);
        flt_dev = dv; flt_phase = fp; flt_short = sh; upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    function automatic logic [1:0] hp_of(input logic [1:0] ph);
        return 2'((int'(ph) + 2) % 4);
    endfunction

    task automatic t_reset();
        rst = 1'b1; upd = 1'b0; phase = 0; gamma = 2'b01; cap_diff = 0;
        flt_dev = 0; flt_phase = 0; flt_short = 0;
        repeat (3) @(negedge clk);
        expect_out("R1 reset", 8'h00, 4'h0, 1'b1, 2'd0);
        rst = 1'b0;
    endtask

    task automatic t_healthy_full();
        apply(2'd0, 2'b01, 5, 3'd0, 2'd0, 1'b0);
        expect_out("R3 full healthy", 8'h0F, 4'h0, 1'b1, hp_of(2'd0));
    endtask

    task automatic t_hold();
        @(negedge clk);
        phase = 2'd1; gamma = 2'b11; flt_dev = 3'd1; flt_phase = 2'd1;
        repeat (3) @(negedge clk);
        expect_out("R2 hold without strobe", 8'h0F, 4'h0, 1'b1, 2'd2);
    endtask

    task automatic t_balance();
        apply(2'd1, 2'b00, -40, 3'd0, 2'd0, 1'b0);
        expect_out("R5 diff negative", 8'h07, 4'h0, 1'b1, hp_of(2'd1));
        apply(2'd1, 2'b00, 40, 3'd0, 2'd0, 1'b0);
        expect_out("R5 diff positive", 8'h0E, 4'h0, 1'b1, hp_of(2'd1));
        apply(2'd2, 2'b00, 0, 3'd0, 2'd0, 1'b0);
        expect_out("R5 diff zero", 8'h0E, 4'h0, 1'b1, hp_of(2'd2));
    endtask

    task automatic t_demag();
        apply(2'd2, 2'b11, 0, 3'd0, 2'd0, 1'b0);
        expect_out("R4 demag healthy", 8'h00, 4'h0, 1'b1, hp_of(2'd2));
        apply(2'd2, 2'b10, 0, 3'd3, 2'd2, 1'b1);
        expect_out("R4 reserved code faulted", 8'h00, 4'h0, 1'b1, hp_of(2'd2));
        apply(2'd0, 2'b11, 0, 3'd1, 2'd0, 1'b0);
        expect_out("R4 demag faulted", 8'h00, 4'h0, 1'b1, hp_of(2'd0));
    endtask

    task automatic t_wrap();
        apply(2'd3, 2'b01, 0, 3'd0, 2'd0, 1'b0);
        expect_out("R6 wrap phase3", 8'h0F, 4'h0, 1'b1, 2'd1);
        apply(2'd2, 2'b01, 0, 3'd0, 2'd0, 1'b0);
        expect_out("R6 wrap phase2", 8'h0F, 4'h0, 1'b1, 2'd0);
    endtask

    task automatic t_dev1_open();
        apply(2'd0, 2'b01, 0, 3'd1, 2'd0, 1'b0);
        expect_out("R7 dev1 open full", 8'h0E, 4'h5, 1'b0, 2'd2);
    endtask

    task automatic t_dev_s8();
        apply(2'd1, 2'b01, 0, 3'd2, 2'd1, 1'b0);
        expect_out("R8 dev2 open full", 8'h8C, 4'h5, 1'b0, 2'd3);
        apply(2'd3, 2'b01, 0, 3'd1, 2'd3, 1'b1);
        expect_out("R8 dev1 short full", 8'h8C, 4'h5, 1'b0, 2'd1);
        apply(2'd2, 2'b01, 0, 3'd2, 2'd2, 1'b1);
        expect_out("R8 dev2 short full", 8'h8C, 4'h5, 1'b0, 2'd0);
    endtask

    task automatic t_dev12_half();
        apply(2'd0, 2'b00, -100, 3'd1, 2'd0, 1'b0);
        expect_out("R9 dev1 half diff neg", 8'h8C, 4'h0, 1'b1, 2'd2);
        apply(2'd0, 2'b00, 100, 3'd2, 2'd0, 1'b1);
        expect_out("R9 dev2 short half diff pos", 8'h8C, 4'h0, 1'b1, 2'd2);
    endtask

    task automatic t_dev34();
        apply(2'd1, 2'b01, 0, 3'd3, 2'd1, 1'b0);
        expect_out("R10 dev3 open full", 8'h43, 4'hA, 1'b0, 2'd3);
        apply(2'd3, 2'b01, 0, 3'd4, 2'd3, 1'b1);
        expect_out("R10 dev4 short full", 8'h43, 4'hA, 1'b0, 2'd1);
        apply(2'd1, 2'b00, -7, 3'd4, 2'd1, 1'b0);
        expect_out("R10 dev4 half", 8'h43, 4'h0, 1'b1, 2'd3);
    endtask

    task automatic t_other_phase();
        apply(2'd1, 2'b00, -9, 3'd1, 2'd0, 1'b0);
        expect_out("R11 fault elsewhere balance", 8'h07, 4'h0, 1'b1, 2'd3);
        apply(2'd0, 2'b01, 0, 3'd5, 2'd0, 1'b0);
        expect_out("R11 dev index 5 ignored", 8'h0F, 4'h0, 1'b1, 2'd2);
        apply(2'd0, 2'b00, 3, 3'd0, 2'd0, 1'b1);
        expect_out("R11 dev index 0 ignored", 8'h0E, 4'h0, 1'b1, 2'd2);
    endtask

    initial begin
        t_reset();
        t_healthy_full();
        t_hold();
        t_balance();
        t_demag();
        t_wrap();
        t_dev1_open();
        t_dev_s8();
        t_dev12_half();
        t_dev34();
        t_other_phase();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got running exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule